// File: doc/BRIEF.md
# Averaging LFO Rate Filter with Deadband

This block turns a stream of noisy 10-bit converter readings into a steady 24-bit phase increment for a low-frequency oscillator. Every reading that arrives with its completion strobe is summed. Once a fixed window of 256 readings has been collected, the sum is scaled down to 16 bits and raised by a minimum-rate floor. The result is a candidate rate.

The candidate replaces the current rate only if it differs from it by at least a fixed threshold. Small jitter on the converter input therefore never reaches the oscillator. Whether or not the rate changes, the sum restarts from zero for the next window.

A single-cycle tick marks each window end, so that neighbouring control logic (for example a button sampler) can run on the same slow cadence. The window-end update takes one cycle. A strobe arriving in the very next cycle is summed into the new window, so no reading is lost.

Top module: `lfo_rate_filter`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rate_o` becomes 0x001000 and `tick_o` becomes 0.
- R2: `tick_o` is high for exactly the one cycle after the clock edge that samples the 256th strobe of a window, and it is low at all other times.
- R3: At a window end the candidate equals (sum of the 256 readings >> 2) + 0x000100, formed in 24 bits. An all-1023 window gives 0x0100C0.
- R4: If candidate >= rate, the magnitude is candidate - rate. Otherwise the magnitude is the bitwise complement of the 24-bit difference, which equals rate - candidate - 1. When the magnitude is 0x40 or more, `rate_o` takes the candidate at that same edge.
- R5: When the magnitude is below 0x40, `rate_o` keeps its value. For example, a candidate exactly 0x40 below the rate is held.
- R6: `rate_o` changes only at edges that also raise `tick_o`.
- R7: The sum is cleared at every window end, whether or not the rate was updated, so each window depends only on its own 256 readings.
- R8: A strobe in the cycle directly after a window end counts as the first reading of the next window.
- R9: `conv_data_i` is ignored in cycles where `conv_done_i` is low. Such cycles neither add to the sum nor advance the window count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| conv_done_i | input | 1 | One-cycle strobe: a new reading is valid |
| conv_data_i | input | 10 | Converter reading, unsigned |
| rate_o | output | 24 | Current LFO phase increment |
| tick_o | output | 1 | One-cycle pulse after each window end |

## Verification
If the window counter is wrong, `tick_o` appears at the wrong place within the first 256 strobes, and the bench compares its timing on every cycle. A corrupted sum, scaling or offset shows only at the next tick, and only when it moves the decision across the threshold. For that reason, the directed windows sit exactly on the threshold on both sides, where the one-count skew of the complement applies. A rate register that drifts between ticks shows as an output change on a cycle without a tick, and that is caught the cycle it occurs.

// File: rtl/lfo_rate_pkg.sv
// Package: shared decision type for the LFO rate filter.
// Assumes: nothing; pure type definitions.
package lfo_rate_pkg;

    // Outcome of the deadband comparison at a window end.
    typedef enum logic {
        ACT_HOLD = 1'b0,
        ACT_LOAD = 1'b1
    } rate_action_e;

endpackage

// File: rtl/rate_sample_accum.sv
// Module: rate_sample_accum
// Sums strobed converter readings over a window of 2**WIN_LOG2 strobes.
// On the strobe that completes the window, win_end_o is high in that cycle
// and win_sum_o presents the full sum including that reading. The register
// is then cleared at the same edge, so a strobe one cycle later starts the
// next window.
// Assumes: conv_done_i is synchronous to clk; WIN_LOG2 >= 1.
module rate_sample_accum #(
    parameter int SAMPLE_W = 10,
    parameter int WIN_LOG2 = 8,
    localparam int SUM_W   = SAMPLE_W + WIN_LOG2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                conv_done_i,
    input  logic [SAMPLE_W-1:0] conv_data_i,
    output logic                win_end_o,
    output logic [SUM_W-1:0]    win_sum_o
);

    logic [SUM_W-1:0]    acc_q;
    logic [WIN_LOG2-1:0] cnt_q;
    logic [SUM_W-1:0]    sample_ext;

    // Zero-extend the reading to the accumulator width.
    always_comb begin
        sample_ext = {{WIN_LOG2{1'b0}}, conv_data_i};
    end

    // Window-end detect and the sum that includes the current reading.
    always_comb begin
        win_end_o = conv_done_i && (cnt_q == {WIN_LOG2{1'b1}});
        win_sum_o = acc_q + sample_ext;
    end

    // Strobe counter: wraps naturally at the window length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (conv_done_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Accumulator: adds on strobe, clears when the window closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (win_end_o) begin
            acc_q <= '0;
        end else if (conv_done_i) begin
            acc_q <= win_sum_o;
        end
    end

endmodule

// File: rtl/rate_deadband_judge.sv
// Module: rate_deadband_judge
// Purely combinational. Scales the window sum, adds the minimum-rate
// floor, and decides whether the candidate differs from the current rate
// by at least DEADBAND. A negative difference is turned into a magnitude
// by bitwise complement, which is one count short of the true value.
// Assumes: RATE_W > SUM_W so the scaled sum plus floor cannot overflow.
module rate_deadband_judge
    import lfo_rate_pkg::*;
#(
    parameter int          SUM_W       = 18,
    parameter int          RATE_W      = 24,
    parameter int          SCALE_SHIFT = 2,
    parameter logic [23:0] MIN_RATE    = 24'h000100,
    parameter logic [23:0] DEADBAND    = 24'h000040
) (
    input  logic [SUM_W-1:0]  win_sum_i,
    input  logic [RATE_W-1:0] cur_rate_i,
    output logic [RATE_W-1:0] cand_o,
    output rate_action_e      action_o
);

    localparam int PAD_W = RATE_W - SUM_W;

    logic [SUM_W-1:0]  scaled;
    logic [RATE_W:0]   diff_ext;
    logic              diff_neg;
    logic [RATE_W-1:0] diff_mag;

    // Rescale the window sum and add the minimum-rate floor.
    always_comb begin
        scaled = win_sum_i >> SCALE_SHIFT;
        cand_o = {{PAD_W{1'b0}}, scaled} + RATE_W'(MIN_RATE);
    end

    // Signed difference with borrow, then ones-complement magnitude.
    always_comb begin
        diff_ext = {1'b0, cand_o} - {1'b0, cur_rate_i};
        diff_neg = diff_ext[RATE_W];
        diff_mag = diff_neg ? ~diff_ext[RATE_W-1:0] : diff_ext[RATE_W-1:0];
    end

    // Deadband decision.
    always_comb begin
        action_o = (diff_mag < RATE_W'(DEADBAND)) ? ACT_HOLD : ACT_LOAD;
    end

endmodule

// File: rtl/rate_hold_reg.sv
// Module: rate_hold_reg
// Holds the published rate and emits the window tick. The rate loads
// the candidate only at a window end with a LOAD decision. The tick is the
// window-end strobe delayed by one register.
// Assumes: win_end_i is a single-cycle pulse.
module rate_hold_reg
    import lfo_rate_pkg::*;
#(
    parameter int          RATE_W     = 24,
    parameter logic [23:0] RESET_RATE = 24'h001000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_end_i,
    input  rate_action_e      action_i,
    input  logic [RATE_W-1:0] cand_i,
    output logic [RATE_W-1:0] rate_o,
    output logic              tick_o
);

    // Rate register: reset value, then conditional load at window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_o <= RATE_W'(RESET_RATE);
        end else if (win_end_i && (action_i == ACT_LOAD)) begin
            rate_o <= cand_i;
        end
    end

    // Tick register: one pulse per window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_o <= 1'b0;
        end else begin
            tick_o <= win_end_i;
        end
    end

endmodule

// File: rtl/lfo_rate_filter.sv
// Module: lfo_rate_filter (top)
// Averages 2**WIN_LOG2 converter readings and applies the result as a new
// LFO rate only when it moves by at least DEADBAND. Publishes a tick
// after each window end.
// Assumes: readings are unsigned and strobes are single-cycle.
module lfo_rate_filter
    import lfo_rate_pkg::*;
#(
    parameter int          SAMPLE_W    = 10,
    parameter int          WIN_LOG2    = 8,
    parameter int          RATE_W      = 24,
    parameter int          SCALE_SHIFT = 2,
    parameter logic [23:0] MIN_RATE    = 24'h000100,
    parameter logic [23:0] DEADBAND    = 24'h000040,
    parameter logic [23:0] RESET_RATE  = 24'h001000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                conv_done_i,
    input  logic [SAMPLE_W-1:0] conv_data_i,
    output logic [RATE_W-1:0]   rate_o,
    output logic                tick_o
);

    localparam int SUM_W = SAMPLE_W + WIN_LOG2;

    logic              win_end;
    logic [SUM_W-1:0]  win_sum;
    logic [RATE_W-1:0] cand;
    rate_action_e      action;

    rate_sample_accum #(
        .SAMPLE_W (SAMPLE_W),
        .WIN_LOG2 (WIN_LOG2)
    ) u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_done_i (conv_done_i),
        .conv_data_i (conv_data_i),
        .win_end_o   (win_end),
        .win_sum_o   (win_sum)
    );

    rate_deadband_judge #(
        .SUM_W       (SUM_W),
        .RATE_W      (RATE_W),
        .SCALE_SHIFT (SCALE_SHIFT),
        .MIN_RATE    (MIN_RATE),
        .DEADBAND    (DEADBAND)
    ) u_judge (
        .win_sum_i  (win_sum),
        .cur_rate_i (rate_o),
        .cand_o     (cand),
        .action_o   (action)
    );

    rate_hold_reg #(
        .RATE_W     (RATE_W),
        .RESET_RATE (RESET_RATE)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_end_i (win_end),
        .action_i  (action),
        .cand_i    (cand),
        .rate_o    (rate_o),
        .tick_o    (tick_o)
    );

endmodule

// File: rtl/lfo_rate_filter_chk.sv
// Module: lfo_rate_filter_chk
// Port-level checker bound to lfo_rate_filter. It keeps the previous
// rate in a register of its own and checks the timing and size of rate
// changes and the shape of the tick.
// Assumes: synchronous active-low reset, WIN_LOG2 >= 1.
module lfo_rate_filter_chk #(
    parameter int          RATE_W   = 24,
    parameter logic [23:0] MIN_RATE = 24'h000100,
    parameter logic [23:0] DEADBAND = 24'h000040
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_done_i,
    input logic [RATE_W-1:0] rate_o,
    input logic              tick_o
);

    logic [RATE_W-1:0] prev_rate;
    logic [RATE_W-1:0] step_mag;

    // Remember last cycle's published rate.
    always_ff @(posedge clk) begin
        prev_rate <= rate_o;
    end

    // Size of the last rate step, with the same complement skew.
    always_comb begin
        step_mag = (rate_o >= prev_rate) ? (rate_o - prev_rate)
                                         : (prev_rate - rate_o - 1'b1);
    end

    // R2
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    // R2
    tick_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done_i |=> !tick_o);

    // R6
    rate_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_o != prev_rate) |-> tick_o);

    // R4
    step_exceeds_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_o != prev_rate) |-> (step_mag >= RATE_W'(DEADBAND)));

    // R3
    rate_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rate_o >= RATE_W'(MIN_RATE));

endmodule

bind lfo_rate_filter lfo_rate_filter_chk #(
    .RATE_W   (RATE_W),
    .MIN_RATE (MIN_RATE),
    .DEADBAND (DEADBAND)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_done_i (conv_done_i),
    .rate_o      (rate_o),
    .tick_o      (tick_o)
);

// File: tb/lfo_rate_filter_tb.sv
module lfo_rate_filter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_done = 1'b0;
    logic [9:0]  conv_data = '0;
    logic [23:0] rate_o;
    logic        tick_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int unsigned m_sum = 0;
    int          m_cnt = 0;
    logic [23:0] m_rate = 24'h001000;

    always #2 clk = ~clk;

    lfo_rate_filter u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_done_i (conv_done),
        .conv_data_i (conv_data),
        .rate_o      (rate_o),
        .tick_o      (tick_o)
    );

    // Expected next rate from a window sum (requirements R3, R4, R5).
    function automatic logic [23:0] next_rate(input int unsigned sum, input logic [23:0] cur);
        logic [23:0] cand;
        logic [23:0] mag;
        cand = 24'(sum >> 2) + 24'h000100;
        if (cand >= cur) mag = cand - cur;
        else             mag = cur - cand - 24'd1;
        return (mag >= 24'h40) ? cand : cur;
    endfunction

    task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle, update the model, and compare after the edge.
    task automatic step(input logic stb, input logic [9:0] d, input string tag);
        bit exp_tick;
        @(negedge clk);
        conv_done = stb;
        conv_data = d;
        exp_tick = 1'b0;
        if (stb) begin
            m_sum += d;
            m_cnt++;
            if (m_cnt == 256) begin
                m_rate = next_rate(m_sum, m_rate);
                exp_tick = 1'b1;
                m_sum = 0;
                m_cnt = 0;
            end
        end
        @(posedge clk);
        #1;
        check(tick_o == exp_tick, "R2", 24'(tick_o), 24'(exp_tick));
        check(rate_o == m_rate, exp_tick ? tag : "R6", rate_o, m_rate);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd7719));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(rate_o == 24'h001000, "R1", rate_o, 24'h001000);
        check(tick_o == 1'b0, "R1", 24'(tick_o), 24'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4: all-zero window drops the rate to the floor 0x100.
        for (int i = 0; i < 256; i++) step(1'b1, 10'd0, "R4");

        // R9: 252 ones give candidate 0x13F, held; idle junk must not count.
        for (int i = 0; i < 256; i++) begin
            step(1'b1, (i < 252) ? 10'd1 : 10'd0, "R9");
            step(1'b0, 10'h3FF, "R9");
        end

        // R8: back-to-back strobes of ones give 0x140, exactly the threshold.
        for (int i = 0; i < 256; i++) step(1'b1, 10'd1, "R8");

        // R5: candidate 0x100 lies 0x40 below the rate; the complement skew holds it.
        for (int i = 0; i < 256; i++) step(1'b1, 10'd0, "R5");

        // R3: full-scale window gives 0x0100C0.
        for (int i = 0; i < 256; i++) step(1'b1, 10'h3FF, "R3");

        // R7: random windows around a per-window level, with gaps.
        for (int w = 0; w < 8; w++) begin
            int base;
            base = int'($urandom_range(1023, 0));
            while (m_cnt != 0 || w == 0) begin
                logic       stb;
                int         v;
                stb = ($urandom_range(9, 0) < 7);
                v = base + int'($urandom_range(6, 0)) - 3;
                if (v < 0) v = 0;
                if (v > 1023) v = 1023;
                step(stb, 10'(v), "R7");
                if (w == 0 && m_cnt == 0 && stb) break;
            end
        end

        finish_run();
    end

endmodule